// File: doc/BRIEF.md
# Watchdog Timer with Unlock Feed

This block is a bus-attached watchdog. It has three registers: a mode register, a time-out constant and a feed port. A down-counter is loaded from the constant and decremented once every four clock cycles. If software does not restart the count before it runs out, the block either raises a level interrupt request or emits a one-cycle system reset request. Which of the two happens depends on the mode bits.

Software arms the watchdog by setting the enable bit. The counter stays idle until software writes the two-byte unlock pattern (0xAA, then 0x55) to the feed port, and each later pattern restarts the full interval. The enable and reset-enable bits are set-only: software cannot turn the watchdog off again. The time-out flag is cleared only by software or by the block's own reset input, so it survives a watchdog-issued system reset. The `rst_n` input therefore carries the external (power-on or pin) reset only.

The bus uses a single-cycle write strobe and combinational read data. Register offsets are 0x0 for mode, 0x4 for the constant and 0x8 for feed.

Top module: `feed_watchdog`

## Requirements
- R1: With enable set, a write of low byte 0xAA to offset 0x8, followed by the very next bus write carrying low byte 0x55 to offset 0x8, reloads the counter from the constant and starts it. If no further feed occurs, the time-out takes effect at the clock edge 4*(constant+1) cycles after the edge that accepts the 0x55 write.
- R2: With enable at 0, a complete feed pattern starts nothing. With enable at 1 but no feed pattern accepted, no time-out ever occurs.
- R3: Mode bit 0 (enable) and mode bit 1 (reset-enable) can only be set by writing 1 to them. Writing 0 to either bit leaves it unchanged.
- R4: A feed pattern is broken in any of these cases, and the broken pattern reloads and starts nothing:
  - a write of 0x55 without an immediately preceding 0xAA;
  - any other value written to offset 0x8;
  - a write to another register between the 0xAA and the 0x55.
- R5: In interrupt mode (enable=1, reset-enable=0), a time-out has these effects:
  - it sets mode bit 3 (interrupt flag) and mode bit 2 (time-out flag);
  - `irq` goes high and stays high until an external reset;
  - the counter stops;
  - enable stays set.
- R6: In reset mode (both bits at 1), a time-out has these effects:
  - `sys_rst_req` goes high for exactly one cycle;
  - enable, reset-enable and the interrupt flag are cleared;
  - the time-out flag is set;
  - the counter stops;
  - `irq` stays low.
- R7: Writing 0 to mode bit 2 clears the time-out flag, and writing 1 to it has no effect. The flag survives a reset-mode time-out and is cleared by `rst_n`.
- R8: The constant register at offset 0x4 reads 0x000000FF after reset. A written value below 0xFF is stored as 0xFF, and any other value is stored unchanged.
- R9: Mode bits 31:4 read as 0. Writes to mode bits 3 and 7:4 have no effect. Offset 0x8 and unmapped offsets read 0.
- R10: A valid feed while the counter runs restarts the full 4*(constant+1) interval.
- R11: After `rst_n` is asserted low at a clock edge, the mode register reads 0, the constant reads 0xFF, and `irq` and `sys_rst_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | External synchronous reset, active low |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request, follows the interrupt flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is the only thing that ever clears state from outside the block;
- at most one register is written per cycle, which a single address bus guarantees;
- bus inputs are stable across each rising edge.

The stimulus drives every bus cycle on the falling edge and keeps each write strobe to one cycle. Between the directed steps it leaves the strobe low, so feed patterns are broken only where a step intends it. Reset is held low for several whole cycles, and the bench does not apply it while the design's time-out flag is being observed for persistence.

// File: rtl/wdg_pkg.sv
// Shared constants and types for the feed-sequence watchdog.
// Assumes byte offsets fit in the bus address width chosen at the top.
package wdg_pkg;
    localparam int OFF_MODE  = 'h0;
    localparam int OFF_CONST = 'h4;
    localparam int OFF_FEED  = 'h8;

    localparam int BIT_EN    = 0;
    localparam int BIT_RSTEN = 1;
    localparam int BIT_TOF   = 2;

    localparam logic [7:0] KEY_ARM  = 8'hAA;
    localparam logic [7:0] KEY_FIRE = 8'h55;

    typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_t;

    // Mode register image, bit 3 down to bit 0.
    typedef struct packed {
        logic intf;
        logic tof;
        logic rsten;
        logic en;
    } mode_t;
endpackage

// File: rtl/wdg_feed_seq.sv
// Unlock-pattern detector for the feed port.
// Recognises two consecutive bus writes to the feed offset carrying KEY_ARM,
// then KEY_FIRE. Any other write breaks the pattern. Assumes one write per cycle.
module wdg_feed_seq
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        key,
    output logic              feed_ok
);
    seq_t state_q;
    logic hit;

    // Decode a write to the feed port.
    assign hit = wr && (addr == ADDR_W'(OFF_FEED));

    // Track whether the previous bus write was the arming key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else if (wr)
            state_q <= (hit && key == KEY_ARM) ? SEQ_ARMED : SEQ_IDLE;
    end

    // Fire when the second key follows the arming key directly.
    assign feed_ok = hit && (key == KEY_FIRE) && (state_q == SEQ_ARMED);
endmodule

// File: rtl/wdg_tick_div.sv
// Clock divider producing one count-enable tick every DIV cycles while running.
// clr restarts the phase so a reload always begins a full tick period.
module wdg_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    generate
        if (DIV < 2) begin : g_nodiv
            // Every running cycle is a tick.
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            // Step the phase while running, wrapping at DIV.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    phase_q <= '0;
                else if (run)
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end

            assign tick = run && (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/wdg_downcount.sv
// Watchdog down-counter: loads on request and decrements on each tick.
// underflow flags a tick that finds the count already at zero; a load in
// the same cycle wins and suppresses it.
module wdg_downcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             underflow
);
    logic [CNT_W-1:0] cnt_q;

    // Reload or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign underflow = tick && !load && (cnt_q == '0);
endmodule

// File: rtl/feed_watchdog.sv
// Top of the feed-sequence watchdog: register file, run control and read mux.
// rst_n is the external reset only; the block clears its own state on a
// reset-mode time-out, so the time-out flag survives the system reset it asks for.
module feed_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 4,
    parameter int TC_FLOOR = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst_req
);
    localparam logic [DATA_W-1:0] FLOOR_V = DATA_W'(TC_FLOOR);
    localparam int MODE_W = $bits(mode_t);

    mode_t             mode_q;
    logic [DATA_W-1:0] tc_q;
    logic              running_q;
    logic              rst_req_q;
    logic              wr_mode, wr_const;
    logic              feed_ok, load, tick, uf;

    // Register write decode.
    assign wr_mode  = bus_we && (bus_addr == ADDR_W'(OFF_MODE));
    assign wr_const = bus_we && (bus_addr == ADDR_W'(OFF_CONST));
    assign load     = feed_ok && mode_q.en;

    wdg_feed_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr(bus_we), .addr(bus_addr),
        .key(bus_wdata[7:0]), .feed_ok(feed_ok)
    );

    wdg_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(load), .run(running_q), .tick(tick)
    );

    wdg_downcount #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(tc_q),
        .tick(tick), .underflow(uf)
    );

    // Mode bits: software sets en/rsten and clears tof; a time-out overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            if (wr_mode) begin
                mode_q.en    <= mode_q.en    | bus_wdata[BIT_EN];
                mode_q.rsten <= mode_q.rsten | bus_wdata[BIT_RSTEN];
                mode_q.tof   <= mode_q.tof   & bus_wdata[BIT_TOF];
            end
            if (uf) begin
                mode_q.tof <= 1'b1;
                if (mode_q.rsten) begin
                    mode_q.en    <= 1'b0;
                    mode_q.rsten <= 1'b0;
                    mode_q.intf  <= 1'b0;
                end else begin
                    mode_q.intf  <= 1'b1;
                end
            end
        end
    end

    // Time-out constant with lower clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_q <= FLOOR_V;
        else if (wr_const)
            tc_q <= (bus_wdata < FLOOR_V) ? FLOOR_V : bus_wdata;
    end

    // Counter runs from the first accepted feed until a time-out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running_q <= 1'b0;
        else if (load)
            running_q <= 1'b1;
        else if (uf)
            running_q <= 1'b0;
    end

    // One-cycle system reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req_q <= 1'b0;
        else
            rst_req_q <= uf && mode_q.rsten;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_MODE))
            bus_rdata[MODE_W-1:0] = mode_q;
        else if (bus_addr == ADDR_W'(OFF_CONST))
            bus_rdata = tc_q;
    end

    assign irq         = mode_q.intf;
    assign sys_rst_req = rst_req_q;
endmodule

// File: rtl/wdg_checker.sv
// Property checker for feed_watchdog, attached by bind.
// Assumes rst_n is the sole external clearing source.
module wdg_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int TC_FLOOR = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              sys_rst_req,
    input logic              en_q,
    input logic              rsten_q,
    input logic              tof_q,
    input logic              running_q,
    input logic [DATA_W-1:0] tc_q,
    input logic              uf
);
    // R3: enable is only lost through a reset-mode time-out.
    p_en_set_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(uf && rsten_q)) |=> en_q);

    // R2: the counter never runs while enable is clear.
    p_no_run_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !running_q);

    // R6: the reset request lasts a single cycle and leaves the flags right.
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);
    p_rst_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (tof_q && !irq && !en_q && !running_q));

    // R5: the interrupt request holds once raised.
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);

    // R8: the stored constant never drops under the floor.
    p_tc_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q >= DATA_W'(TC_FLOOR));

    // R9: upper mode read bits are zero.
    p_mode_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata[DATA_W-1:4] == '0));
endmodule

bind feed_watchdog wdg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TC_FLOOR(TC_FLOOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst_req(sys_rst_req), .en_q(mode_q.en),
    .rsten_q(mode_q.rsten), .tof_q(mode_q.tof), .running_q(running_q),
    .tc_q(tc_q), .uf(uf)
);

// File: tb/feed_watchdog_test.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks tagged by requirement.
module feed_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, sys_rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    feed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sys_rst_req(sys_rst_req)
    );

    // Reference model state.
    bit m_en = 0, m_rs = 0, m_tof = 0, m_int = 0, m_run = 0, m_arm = 0, m_req = 0;
    longint m_tc = 255, m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_rs = 0; m_tof = 0; m_int = 0; m_run = 0;
            m_arm = 0; m_req = 0; m_tc = 255; m_left = 0;
        end else begin
            automatic bit fed = bus_we && bus_addr == 4'h8 &&
                                bus_wdata[7:0] == 8'h55 && m_arm;
            automatic bit restart = fed && m_en;
            automatic bit fire = 0;
            automatic bit old_rs = m_rs;
            if (m_run && !restart) begin
                m_left--;
                if (m_left == 0) fire = 1;
            end
            if (bus_we) m_arm = (bus_addr == 4'h8 && bus_wdata[7:0] == 8'hAA);
            if (bus_we && bus_addr == 4'h0) begin
                if (bus_wdata[0]) m_en = 1;
                if (bus_wdata[1]) m_rs = 1;
                if (!bus_wdata[2]) m_tof = 0;
            end
            if (bus_we && bus_addr == 4'h4)
                m_tc = (bus_wdata < 32'hFF) ? 255 : longint'(bus_wdata);
            if (restart) begin
                m_run = 1;
                m_left = 4 * (m_tc + 1);
            end
            m_req = 0;
            if (fire) begin
                m_run = 0;
                m_tof = 1;
                if (old_rs) begin
                    m_req = 1; m_en = 0; m_rs = 0; m_int = 0;
                end else begin
                    m_int = 1;
                end
            end
        end
    end

    function automatic logic [31:0] m_rdata(logic [3:0] a);
        if (a == 4'h0) return {28'h0, m_int, m_tof, m_rs, m_en};
        if (a == 4'h4) return m_tc[31:0];
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #2;
        if (cmp_on) begin
            check({cur_req, " irq"}, {31'h0, irq}, {31'h0, m_int});
            check({cur_req, " sys_rst_req"}, {31'h0, sys_rst_req}, {31'h0, m_req});
            check({cur_req, " rdata"}, bus_rdata, m_rdata(bus_addr));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic feed();
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R11 reset state
        rd(4'h0, 32'h0, "R11 mode");
        rd(4'h4, 32'hFF, "R11 const");
        check("R11 irq", {31'h0, irq}, 32'h0);
        check("R11 sys_rst_req", {31'h0, sys_rst_req}, 32'h0);

        cur_req = "R8";
        wr(4'h4, 32'h10);  rd(4'h4, 32'hFF, "R8 clamp");
        wr(4'h4, 32'hFE);  rd(4'h4, 32'hFF, "R8 clamp edge");
        wr(4'h4, 32'h300); rd(4'h4, 32'h300, "R8 store");
        wr(4'h4, 32'h100); rd(4'h4, 32'h100, "R8 store2");

        cur_req = "R9";
        wr(4'h0, 32'hFFFF_FFF8);
        rd(4'h0, 32'h0, "R9 reserved and bit3 ignored");
        rd(4'h8, 32'h0, "R9 feed reads 0");
        rd(4'hC, 32'h0, "R9 unmapped reads 0");

        cur_req = "R2";
        feed();
        idle(1100);
        check("R2 feed without enable", {31'h0, irq}, 32'h0);
        wr(4'h0, 32'h1);
        rd(4'h0, 32'h1, "R3 enable set");
        cur_req = "R3";
        wr(4'h0, 32'h0);
        rd(4'h0, 32'h1, "R3 enable write 0 ignored");
        idle(1100);
        check("R2 enable without feed", {31'h0, irq}, 32'h0);

        cur_req = "R4";
        wr(4'h8, 32'hAA); wr(4'h4, 32'h100); wr(4'h8, 32'h55);
        wr(4'h8, 32'h55);
        wr(4'h8, 32'hAA); wr(4'h8, 32'hAB); wr(4'h8, 32'h55);
        idle(1100);
        check("R4 broken patterns", {31'h0, irq}, 32'h0);

        cur_req = "R1";
        feed();
        idle(1027);
        #1 check("R1 before time-out", {31'h0, irq}, 32'h0);
        idle(1);
        #1 check("R1 at time-out", {31'h0, irq}, 32'h1);
        cur_req = "R5";
        rd(4'h0, 32'hD, "R5 flags, enable kept");
        idle(50);
        check("R5 irq held", {31'h0, irq}, 32'h1);
        cur_req = "R7";
        wr(4'h0, 32'h0);
        rd(4'h0, 32'h9, "R7 tof cleared, irq flag kept");

        cur_req = "R11";
        ext_reset();
        rd(4'h0, 32'h0, "R11 after external reset");

        cur_req = "R10";
        wr(4'h4, 32'h100);
        wr(4'h0, 32'h1);
        feed();
        idle(600);
        feed();
        idle(1027);
        #1 check("R10 refeed restarts", {31'h0, irq}, 32'h0);
        idle(1);
        #1 check("R10 time-out after refeed", {31'h0, irq}, 32'h1);
        ext_reset();

        cur_req = "R6";
        wr(4'h4, 32'h100);
        wr(4'h0, 32'h3);
        rd(4'h0, 32'h3, "R3 both set");
        feed();
        idle(1027);
        #1 check("R6 no request yet", {31'h0, sys_rst_req}, 32'h0);
        idle(1);
        #1 check("R6 request pulse", {31'h0, sys_rst_req}, 32'h1);
        idle(1);
        #1 check("R6 pulse ends", {31'h0, sys_rst_req}, 32'h0);
        rd(4'h0, 32'h4, "R6 bits cleared, tof set");
        check("R6 irq low", {31'h0, irq}, 32'h0);

        cur_req = "R7";
        wr(4'h0, 32'h4);
        rd(4'h0, 32'h4, "R7 write 1 keeps tof");
        wr(4'h0, 32'h0);
        rd(4'h0, 32'h0, "R7 write 0 clears tof");
        wr(4'h0, 32'h3);
        feed();
        idle(1030);
        rd(4'h0, 32'h4, "R7 tof survives watchdog reset");
        ext_reset();
        rd(4'h0, 32'h0, "R7 external reset clears tof");

        idle(5);
        finish_run();
    end
endmodule